// File: doc/BRIEF.md
# Double-Precision Special-Value Resolver

This block works beside a binary64 add, multiply and fused multiply-add datapath. For each operation it reports whether the IEEE-754 result is a special value that the arithmetic path must not compute. A special value here is a NaN, a default NaN from an invalid operation, or an infinity that an infinite operand forces. When the result is special, the block gives that value and the invalid-operation flag. The datapath takes the block's result whenever the special flag is high and uses its own rounded sum or product otherwise.

One operation is accepted per cycle on a valid strobe. The operation code selects add, subtract, multiply, multiply-add or multiply-subtract. Operand A is the addend for the fused forms, and B and C are the two multiplicands. All outputs are registered and appear one cycle after the strobe. The block does no finite arithmetic and no rounding.

Top module: `fp64_special_resolver`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous cycle. After reset, all outputs are zero.
- R2: When `out_valid` or `out_special` is low, `out_special` and `out_invalid` are low and `out_result` is zero. `out_invalid` is never high without `out_special`.
- R3: A value is a NaN when bits 62:52 are all ones and bits 51:0 are not zero. It is signalling when bit 51 is 0. A returned NaN always has bit 51 set and keeps its sign and its other bits. A signalling NaN input sets the invalid flag. A quiet NaN alone does not.
- R4: For add, sub and mul, when either operand is a NaN the result is operand A's NaN if A is a NaN, and otherwise B's NaN, quieted. Invalid is set if either operand is signalling.
- R5: Add of opposite-signed infinities, or sub of same-signed infinities, returns the default NaN 0x7FF8000000000000 with invalid set.
- R6: For add and sub with no NaN and no cancellation, an infinite operand gives that infinity with invalid clear. For sub, B's infinity comes out with its sign inverted.
- R7: Mul of infinity and zero returns the default NaN with invalid set. Infinity times any other non-NaN value returns infinity with sign A xor B, with invalid clear.
- R8: For madd and msub, the returned NaN is chosen by the priority A, then C, then B, and is quieted.
- R9: For madd and msub, any signalling NaN among A, B and C sets invalid, even when the NaN returned is a quiet one.
- R10: For madd and msub, when B times C is infinity times zero, a NaN addend is returned quieted with invalid set. Without a NaN addend, the default NaN is returned with invalid set.
- R11: For madd and msub with no NaN, consider an infinite product with sign B xor C, inverted for msub. If A is an infinity of the opposite sign, the result is the default NaN with invalid set. Otherwise the result is that infinity. If the product is finite and A is infinite, A is returned. Invalid is clear in these non-cancelling cases.
- R12: Operation codes are add=0, sub=1, mul=2, madd=3, msub=4. Codes 5 to 7 never give a special result. Operand C has no effect on add, sub or mul.
- R13: Operands that are all finite and not NaN never give a special result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Operation code |
| op_a | input | 64 | Operand A, the addend for fused forms |
| op_b | input | 64 | Operand B |
| op_c | input | 64 | Operand C, used by fused forms only |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_special | output | 1 | Result is a special value |
| out_result | output | 64 | Special value, zero when not special |
| out_invalid | output | 1 | Invalid-operation flag |

## Verification
Directed cases test NaN selection with every mix of quiet and signalling NaNs across operand positions. These cases separate the A-then-B order of the two-operand forms from the A-then-C-then-B order of the fused forms. They also show whether the invalid flag follows any signalling operand or only the one returned. Further cases place infinities and zeros so that the subtract and multiply-subtract sign inversion decides between cancellation and a plain infinity. Infinity times zero is tested with and without a NaN addend. Random operands are drawn per position from zero, finite, subnormal, infinite, quiet and signalling classes, with random signs, payloads and operation codes, unused codes included. These runs cover the interactions between rules, and C carries a NaN during two-operand operations.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int DATA_W = 1 + EXP_W + FRAC_W;
    localparam int QBIT   = FRAC_W - 1;
    localparam int OP_W   = 3;
    localparam int N_OPND = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_MADD = 3'd3,
        OP_MSUB = 3'd4
    } op_e;

    localparam logic [DATA_W-1:0] DEFAULT_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic sign;
        logic is_nan;
        logic is_snan;
        logic is_inf;
        logic is_zero;
    } fclass_t;

    typedef struct packed {
        logic              special;
        logic              invalid;
        logic [DATA_W-1:0] result;
    } verdict_t;

    typedef struct packed {
        logic     valid;
        verdict_t v;
    } state_t;

    function automatic logic [DATA_W-1:0] quieten(input logic [DATA_W-1:0] x);
        logic [DATA_W-1:0] y;
        y       = x;
        y[QBIT] = 1'b1;
        return y;
    endfunction

    function automatic logic [DATA_W-1:0] make_inf(input logic s);
        return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    endfunction

endpackage

// File: rtl/fpsr_classify.sv
module fpsr_classify
    import fpsr_pkg::*;
(
    input  logic [DATA_W-1:0] value_i,
    output fclass_t           class_o
);

    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic              exp_ones;
    logic              exp_zero;
    logic              frac_nz;

    always_comb begin
        expo     = value_i[DATA_W-2 -: EXP_W];
        frac     = value_i[FRAC_W-1:0];
        exp_ones = &expo;
        exp_zero = ~|expo;
        frac_nz  = |frac;

        class_o.sign    = value_i[DATA_W-1];
        class_o.is_nan  = exp_ones & frac_nz;
        class_o.is_snan = exp_ones & frac_nz & ~frac[QBIT];
        class_o.is_inf  = exp_ones & ~frac_nz;
        class_o.is_zero = exp_zero & ~frac_nz;
    end

endmodule

// File: rtl/fpsr_resolve.sv
module fpsr_resolve
    import fpsr_pkg::*;
(
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] c_i,
    input  fclass_t           ca_i,
    input  fclass_t           cb_i,
    input  fclass_t           cc_i,
    output verdict_t          verdict_o
);

    op_e  op;
    logic sb_eff;
    logic prod_bad;
    logic prod_inf;
    logic prod_sign;
    logic any_nan2;
    logic any_nan3;
    logic any_snan2;
    logic any_snan3;

    always_comb begin
        op        = op_e'(op_i);
        sb_eff    = cb_i.sign ^ (op == OP_SUB);
        prod_bad  = (cb_i.is_inf & cc_i.is_zero) | (cb_i.is_zero & cc_i.is_inf);
        prod_inf  = cb_i.is_inf | cc_i.is_inf;
        prod_sign = cb_i.sign ^ cc_i.sign ^ (op == OP_MSUB);
        any_nan2  = ca_i.is_nan | cb_i.is_nan;
        any_nan3  = any_nan2 | cc_i.is_nan;
        any_snan2 = ca_i.is_snan | cb_i.is_snan;
        any_snan3 = any_snan2 | cc_i.is_snan;

        verdict_o = '0;

        case (op)
            OP_ADD, OP_SUB: begin
                if (any_nan2) begin
                    verdict_o.special = 1'b1;
                    verdict_o.invalid = any_snan2;
                    verdict_o.result  = ca_i.is_nan ? quieten(a_i) : quieten(b_i);
                end else if (ca_i.is_inf && cb_i.is_inf && (ca_i.sign != sb_eff)) begin
                    verdict_o.special = 1'b1;
                    verdict_o.invalid = 1'b1;
                    verdict_o.result  = DEFAULT_NAN;
                end else if (ca_i.is_inf) begin
                    verdict_o.special = 1'b1;
                    verdict_o.result  = a_i;
                end else if (cb_i.is_inf) begin
                    verdict_o.special = 1'b1;
                    verdict_o.result  = make_inf(sb_eff);
                end
            end

            OP_MUL: begin
                if (any_nan2) begin
                    verdict_o.special = 1'b1;
                    verdict_o.invalid = any_snan2;
                    verdict_o.result  = ca_i.is_nan ? quieten(a_i) : quieten(b_i);
                end else if ((ca_i.is_inf && cb_i.is_zero) || (ca_i.is_zero && cb_i.is_inf)) begin
                    verdict_o.special = 1'b1;
                    verdict_o.invalid = 1'b1;
                    verdict_o.result  = DEFAULT_NAN;
                end else if (ca_i.is_inf || cb_i.is_inf) begin
                    verdict_o.special = 1'b1;
                    verdict_o.result  = make_inf(ca_i.sign ^ cb_i.sign);
                end
            end

            OP_MADD, OP_MSUB: begin
                if (any_nan3) begin
                    verdict_o.special = 1'b1;
                    verdict_o.invalid = any_snan3 | prod_bad;
                    if (ca_i.is_nan)
                        verdict_o.result = quieten(a_i);
                    else if (cc_i.is_nan)
                        verdict_o.result = quieten(c_i);
                    else
                        verdict_o.result = quieten(b_i);
                end else if (prod_bad) begin
                    verdict_o.special = 1'b1;
                    verdict_o.invalid = 1'b1;
                    verdict_o.result  = DEFAULT_NAN;
                end else if (prod_inf && ca_i.is_inf && (ca_i.sign != prod_sign)) begin
                    verdict_o.special = 1'b1;
                    verdict_o.invalid = 1'b1;
                    verdict_o.result  = DEFAULT_NAN;
                end else if (prod_inf) begin
                    verdict_o.special = 1'b1;
                    verdict_o.result  = make_inf(prod_sign);
                end else if (ca_i.is_inf) begin
                    verdict_o.special = 1'b1;
                    verdict_o.result  = a_i;
                end
            end

            default: verdict_o = '0;
        endcase
    end

endmodule

// File: rtl/fp64_special_resolver.sv
module fp64_special_resolver
    import fpsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] op_c,
    output logic              out_valid,
    output logic              out_special,
    output logic [DATA_W-1:0] out_result,
    output logic              out_invalid
);

    logic [DATA_W-1:0] opnd [N_OPND];
    fclass_t           cls  [N_OPND];
    verdict_t          verdict;
    state_t            st_d;
    state_t            st_q;

    always_comb begin
        opnd[0] = op_a;
        opnd[1] = op_b;
        opnd[2] = op_c;
    end

    generate
        for (genvar i = 0; i < N_OPND; i++) begin : g_cls
            fpsr_classify u_cls (
                .value_i (opnd[i]),
                .class_o (cls[i])
            );
        end
    endgenerate

    fpsr_resolve u_res (
        .op_i      (in_op),
        .a_i       (op_a),
        .b_i       (op_b),
        .c_i       (op_c),
        .ca_i      (cls[0]),
        .cb_i      (cls[1]),
        .cc_i      (cls[2]),
        .verdict_o (verdict)
    );

    always_comb begin
        st_d.valid = in_valid;
        st_d.v     = in_valid ? verdict : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid   = st_q.valid;
    assign out_special = st_q.v.special;
    assign out_result  = st_q.v.result;
    assign out_invalid = st_q.v.invalid;

endmodule

// File: rtl/fpsr_checker.sv
module fpsr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [2:0]  in_op,
    input logic [63:0] op_a,
    input logic [63:0] op_b,
    input logic        out_valid,
    input logic        out_special,
    input logic [63:0] out_result,
    input logic        out_invalid
);

    logic a_snan, a_inf, b_zero, res_nan;

    always_comb begin
        a_snan  = (op_a[62:52] == 11'h7FF) && (op_a[51:0] != 52'd0) && !op_a[51];
        a_inf   = (op_a[62:0] == 63'h7FF0000000000000);
        b_zero  = (op_b[62:0] == 63'd0);
        res_nan = (out_result[62:52] == 11'h7FF) && (out_result[51:0] != 52'd0);
    end

    a_r1_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r1_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_special && !out_invalid && out_result == 64'd0));

    a_r2_plain_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_special |-> (out_result == 64'd0 && !out_invalid));

    a_r3_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (out_special && res_nan) |-> out_result[51]);

    a_r3_add_snan: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd0 && a_snan) |=>
        (out_invalid && out_result == ($past(op_a) | 64'h0008000000000000)));

    a_r7_mul_inf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd2 && a_inf && b_zero) |=>
        (out_invalid && out_result == 64'h7FF8000000000000));

    a_r12_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op > 3'd4) |=> !out_special);

endmodule

bind fp64_special_resolver fpsr_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_op       (in_op),
    .op_a        (op_a),
    .op_b        (op_b),
    .out_valid   (out_valid),
    .out_special (out_special),
    .out_result  (out_result),
    .out_invalid (out_invalid)
);

// File: tb/sim_fp64_special_resolver.sv
`timescale 1ns/1ps
module sim_fp64_special_resolver;

    localparam logic [63:0] ONE  = 64'h3FF0000000000000;
    localparam logic [63:0] TWO  = 64'h4000000000000000;
    localparam logic [63:0] PINF = 64'h7FF0000000000000;
    localparam logic [63:0] NINF = 64'hFFF0000000000000;
    localparam logic [63:0] ZERO = 64'h0;
    localparam logic [63:0] DNAN = 64'h7FF8000000000000;
    localparam logic [63:0] QN1  = 64'h7FF8000000000001;
    localparam logic [63:0] QN2  = 64'h7FF8000000000002;
    localparam logic [63:0] QN3  = 64'h7FF8000000000003;
    localparam logic [63:0] SN1  = 64'h7FF0000000000001;
    localparam logic [63:0] SN2  = 64'h7FF0000000000002;
    localparam logic [63:0] SN3  = 64'h7FF0000000000003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = 3'd0;
    logic [63:0] op_a = '0, op_b = '0, op_c = '0;
    logic        out_valid, out_special, out_invalid;
    logic [63:0] out_result;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    fp64_special_resolver u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .out_valid(out_valid), .out_special(out_special),
        .out_result(out_result), .out_invalid(out_invalid)
    );

    function automatic bit f_nan(input logic [63:0] x);
        return x[62:52] == 11'h7FF && x[51:0] != 0;
    endfunction
    function automatic bit f_snan(input logic [63:0] x);
        return f_nan(x) && !x[51];
    endfunction
    function automatic bit f_inf(input logic [63:0] x);
        return x[62:0] == 63'h7FF0000000000000;
    endfunction
    function automatic bit f_zero(input logic [63:0] x);
        return x[62:0] == 63'd0;
    endfunction
    function automatic logic [63:0] q(input logic [63:0] x);
        return x | 64'h0008000000000000;
    endfunction

    task automatic ref_model(input logic [2:0] op, input logic [63:0] a, b, c,
                             output bit sp, output bit inv, output logic [63:0] res,
                             output string tag);
        bit nb, ps, pz;
        sp = 0; inv = 0; res = 0; tag = "R13";
        if (op == 3'd0 || op == 3'd1) begin
            nb = b[63] ^ (op == 3'd1);
            if (f_nan(a) || f_nan(b)) begin
                sp = 1; inv = f_snan(a) || f_snan(b);
                res = f_nan(a) ? q(a) : q(b); tag = "R4";
            end else if (f_inf(a) && f_inf(b) && a[63] != nb) begin
                sp = 1; inv = 1; res = DNAN; tag = "R5";
            end else if (f_inf(a)) begin
                sp = 1; res = a; tag = "R6";
            end else if (f_inf(b)) begin
                sp = 1; res = {nb, 63'h7FF0000000000000}; tag = "R6";
            end
        end else if (op == 3'd2) begin
            if (f_nan(a) || f_nan(b)) begin
                sp = 1; inv = f_snan(a) || f_snan(b);
                res = f_nan(a) ? q(a) : q(b); tag = "R4";
            end else if ((f_inf(a) && f_zero(b)) || (f_zero(a) && f_inf(b))) begin
                sp = 1; inv = 1; res = DNAN; tag = "R7";
            end else if (f_inf(a) || f_inf(b)) begin
                sp = 1; res = {a[63] ^ b[63], 63'h7FF0000000000000}; tag = "R7";
            end
        end else if (op == 3'd3 || op == 3'd4) begin
            pz = (f_inf(b) && f_zero(c)) || (f_zero(b) && f_inf(c));
            ps = b[63] ^ c[63] ^ (op == 3'd4);
            if (f_nan(a) || f_nan(b) || f_nan(c)) begin
                sp = 1; inv = f_snan(a) || f_snan(b) || f_snan(c) || pz;
                res = f_nan(a) ? q(a) : (f_nan(c) ? q(c) : q(b));
                tag = pz ? "R10" : (inv ? "R9" : "R8");
            end else if (pz) begin
                sp = 1; inv = 1; res = DNAN; tag = "R10";
            end else if ((f_inf(b) || f_inf(c)) && f_inf(a) && a[63] != ps) begin
                sp = 1; inv = 1; res = DNAN; tag = "R11";
            end else if (f_inf(b) || f_inf(c)) begin
                sp = 1; res = {ps, 63'h7FF0000000000000}; tag = "R11";
            end else if (f_inf(a)) begin
                sp = 1; res = a; tag = "R11";
            end
        end else begin
            tag = "R12";
        end
    endtask

    task automatic check(input string tag, input bit sp, input bit inv, input logic [63:0] res);
        total++;
        if (out_valid !== 1'b1 || out_special !== sp || out_invalid !== inv || out_result !== res) begin
            bad++;
            $display("FAIL %s: got v=%0b sp=%0b inv=%0b res=%h, expected v=1 sp=%0b inv=%0b res=%h",
                     tag, out_valid, out_special, out_invalid, out_result, sp, inv, res);
        end
    endtask

    task automatic run_vec(input logic [2:0] op, input logic [63:0] a, b, c, input string force_tag);
        bit sp, inv; logic [63:0] res; string tag;
        ref_model(op, a, b, c, sp, inv, res, tag);
        if (force_tag != "") tag = force_tag;
        in_op = op; op_a = a; op_b = b; op_c = c; in_valid = 1'b1;
        @(negedge clk);
        check(tag, sp, inv, res);
    endtask

    task automatic idle_check();
        in_valid = 1'b0;
        op_a = SN1; op_b = PINF; op_c = SN2;
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || out_special !== 1'b0 || out_invalid !== 1'b0 || out_result !== 64'd0) begin
            bad++;
            $display("FAIL R2: got v=%0b sp=%0b inv=%0b res=%h, expected all zero",
                     out_valid, out_special, out_invalid, out_result);
        end
    endtask

    function automatic logic [63:0] gen_operand();
        logic [63:0] x;
        logic s;
        s = 1'($urandom_range(0, 1));
        case ($urandom_range(0, 6))
            0: x = {s, 63'd0};
            1: x = {s, 11'($urandom_range(1, 2046)), $urandom(), 20'($urandom())};
            2: x = {s, 11'h7FF, 52'd0};
            3: x = {s, 11'h7FF, 1'b1, 19'($urandom()), $urandom()};
            4: x = {s, 11'h7FF, 1'b0, 19'($urandom()), $urandom() | 32'd1};
            5: x = {s, 11'd0, 20'($urandom()), $urandom() | 32'd1};
            default: x = {s, 11'($urandom_range(1000, 1046)), 20'd0, 32'd0};
        endcase
        return x;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || out_special !== 1'b0 || out_invalid !== 1'b0 || out_result !== 64'd0) begin
            bad++;
            $display("FAIL R1: reset outputs v=%0b sp=%0b inv=%0b res=%h, expected zeros",
                     out_valid, out_special, out_invalid, out_result);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R3 / R4: two-operand NaN handling
        run_vec(3'd0, ONE, QN1, ZERO, "R3");
        run_vec(3'd0, ONE, SN1, ZERO, "R3");
        run_vec(3'd0, SN1, SN2, ZERO, "R4");
        run_vec(3'd0, QN1, SN2, ZERO, "R4");
        run_vec(3'd0, SN1, QN2, ZERO, "R4");
        run_vec(3'd1, {1'b1, QN1[62:0]}, ONE, ZERO, "R3");
        run_vec(3'd2, ONE, SN2, ZERO, "R4");
        idle_check();
        // R5 / R6: infinities in add and sub
        run_vec(3'd0, PINF, NINF, ZERO, "R5");
        run_vec(3'd1, PINF, PINF, ZERO, "R5");
        run_vec(3'd0, ONE, PINF, ZERO, "R6");
        run_vec(3'd1, ONE, PINF, ZERO, "R6");
        run_vec(3'd1, NINF, PINF, ZERO, "R6");
        // R7: multiply
        run_vec(3'd2, PINF, ZERO, ZERO, "R7");
        run_vec(3'd2, NINF, TWO, ZERO, "R7");
        // R8: fused NaN priority
        run_vec(3'd3, QN1, ONE, ONE, "R8");
        run_vec(3'd3, ONE, QN2, ONE, "R8");
        run_vec(3'd3, ONE, ONE, QN3, "R8");
        run_vec(3'd3, QN1, QN2, ONE, "R8");
        run_vec(3'd3, QN1, ONE, QN3, "R8");
        run_vec(3'd3, ONE, QN2, QN3, "R8");
        run_vec(3'd3, QN1, QN2, QN3, "R8");
        run_vec(3'd4, ONE, ONE, {1'b1, QN3[62:0]}, "R8");
        // R9: signalling anywhere raises invalid
        run_vec(3'd3, SN1, ONE, ONE, "R9");
        run_vec(3'd3, QN1, SN2, ONE, "R9");
        run_vec(3'd4, ONE, SN2, QN3, "R9");
        // R10: infinity times zero in fused forms
        run_vec(3'd3, ONE, PINF, ZERO, "R10");
        run_vec(3'd3, SN1, PINF, ZERO, "R10");
        run_vec(3'd3, QN1, PINF, ZERO, "R10");
        // R11: fused infinities
        run_vec(3'd4, PINF, PINF, ONE, "R11");
        run_vec(3'd3, PINF, PINF, ONE, "R11");
        run_vec(3'd3, NINF, ONE, TWO, "R11");
        // R12: unused codes and C ignored by two-operand forms
        run_vec(3'd5, SN1, PINF, NINF, "R12");
        run_vec(3'd7, PINF, NINF, ZERO, "R12");
        run_vec(3'd0, ONE, TWO, SN3, "R12");
        run_vec(3'd2, TWO, ONE, PINF, "R12");
        // R13: all finite
        run_vec(3'd3, ONE, TWO, ONE, "R13");
        idle_check();

        for (int i = 0; i < 4000; i++) begin
            run_vec(3'($urandom_range(0, 7)), gen_operand(), gen_operand(), gen_operand(), "");
            if (($urandom() & 32'h1F) == 0) idle_check();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule